// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block places incoming frames into a circular region of a local packet memory. The region is carved into fixed-size pages, and a frame always begins at the start of a page. A host programs the first page of the region and the page just past its end. After that it only moves a boundary pointer forward as it consumes frames. The block keeps a current-page pointer at the page where the next frame will land. It turns the incoming byte stream into memory write addresses and wraps those addresses from the end of the region back to its first page. After each accepted frame it writes a small header at the front of that frame's first page.

Free space is judged only in whole pages. A frame that would reach the page the host still owns is discarded. The current page then stays where it was, and a sticky overflow flag rises. The flag stays set until the host next moves the boundary. Because of this rule, a ring of N pages holds at most N-1 pages of frames. When the current page equals the boundary, the ring is empty.

Top module: `rx_page_ring`

## Requirements
- R1: While reset is held and on the first cycle after it, memWrEn and overflow are 0, inReady is 1, and curPage and bndPage both equal the DEF_START parameter.
- R2: A config write with cfgSel=1 loads the first ring page and sets curPage and bndPage to the written value. A write with cfgSel=2 loads the page just past the ring's last page. Both writes take effect only when no frame is in progress and no byte is taken in that cycle; otherwise they are ignored.
- R3: A config write with cfgSel=3 loads bndPage in any cycle and clears the overflow flag. If a drop happens in the same cycle, the flag stays set.
- R4: The first byte of a frame is written at page curPage, offset 4. Each further byte goes to the next offset. The write appears on memWrEn/memAddr/memData in the cycle after the byte is taken. memAddr carries the page number in its upper PAGE_W bits and the offset in its lower OFF_W bits.
- R5: When a byte lands on the last offset of a page and the frame continues, the next byte goes to offset 0 of the following page. The page following the last ring page is the first ring page.
- R6: After the last byte of an accepted frame, four header bytes are written at offsets 0 to 3 of the frame's first page: 0x01, the next-page number, the payload byte count low byte, then the count high byte. curPage then becomes that next-page number, which is the page after the frame's last byte, wrapped.
- R7: After an accepted frame, inReady is low for exactly 4 cycles. Bytes offered while inReady is low are not taken and produce no memory write.
- R8: A frame is dropped in two cases. The first is when a byte on a page's last offset is followed by more bytes and the next page equals bndPage. The second is when the frame's last byte leaves a next page equal to bndPage. On a drop, the rest of the frame is discarded with no writes and no header is written. curPage stays unchanged and overflow is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Config write strobe |
| cfgSel | input | 2 | Config target: 1 first page, 2 end page, 3 boundary |
| cfgData | input | PAGE_W | Config write value |
| inValid | input | 1 | Incoming byte valid |
| inData | input | 8 | Incoming byte |
| inLast | input | 1 | Marks the final byte of a frame |
| inReady | output | 1 | Block can take a byte this cycle |
| memWrEn | output | 1 | Packet memory write enable |
| memAddr | output | PAGE_W+OFF_W | Packet memory byte address |
| memData | output | 8 | Packet memory write data |
| curPage | output | PAGE_W | Page where the next frame starts |
| bndPage | output | PAGE_W | Oldest page still owned by the host |
| overflow | output | 1 | Sticky frame-dropped flag |

## Verification
The bench builds the block with PAGE_W=8, OFF_W=4 and the default reset pages, so a page holds only 16 bytes. It programs a four-page ring. Frames of a few dozen bytes therefore cross page edges, wrap from the end page to the first page, fill the ring to one page short, and run into the boundary both mid-frame and on the last byte. A frame that ends exactly on a page's final offset and a single-byte frame that hits the boundary both occur within eight short frames.

// File: rtl/rx_page_ring_pkg.sv
package rx_page_ring_pkg;

  localparam int HDR_BYTES = 4;
  localparam int HDR_IDX_W = $clog2(HDR_BYTES);
  localparam int CNT_W = 16;
  localparam logic [7:0] HDR_STATUS_OK = 8'h01;

  typedef enum logic [1:0] {
    CFG_NONE  = 2'd0,
    CFG_START = 2'd1,
    CFG_STOP  = 2'd2,
    CFG_BOUND = 2'd3
  } cfgSel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_DISCARD,
    ST_HDR
  } ringState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 accept;
    logic                 firstByte;
    logic                 advance;
    logic                 drop;
    logic                 endOk;
    logic                 hdrWr;
    logic [HDR_IDX_W-1:0] hdrIdx;
    logic                 commit;
    logic                 cfgOpen;
  } ringStrobe_t;

  // pointer conditions from datapath to control
  typedef struct packed {
    logic offEnd;
    logic hitBnd;
  } ringStatus_t;

endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_page_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inLast,
  input  ringStatus_t status,
  output ringStrobe_t strobe,
  output logic        inReady
);

  ringState_e state, stateNext;
  logic [HDR_IDX_W-1:0] hdrCnt;
  logic take;
  logic checkPt;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    inReady   = (state != ST_HDR);
    take      = inValid && inReady;
    checkPt   = inLast || status.offEnd;
    case (state)
      ST_IDLE, ST_RECV: begin
        if (take) begin
          strobe.accept    = 1'b1;
          strobe.firstByte = (state == ST_IDLE);
          if (checkPt && status.hitBnd) begin
            strobe.drop = 1'b1;
            stateNext   = inLast ? ST_IDLE : ST_DISCARD;
          end else if (inLast) begin
            strobe.endOk = 1'b1;
            stateNext    = ST_HDR;
          end else begin
            strobe.advance = 1'b1;
            stateNext      = ST_RECV;
          end
        end
      end
      ST_DISCARD: begin
        if (take && inLast) stateNext = ST_IDLE;
      end
      ST_HDR: begin
        strobe.hdrWr  = 1'b1;
        strobe.hdrIdx = hdrCnt;
        if (hdrCnt == HDR_IDX_W'(HDR_BYTES - 1)) begin
          strobe.commit = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    strobe.cfgOpen = (state == ST_IDLE) && !take;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hdrCnt <= '0;
    end else begin
      state  <= stateNext;
      hdrCnt <= (state == ST_HDR) ? hdrCnt + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/rx_ring_datapath.sv
module rx_ring_datapath
  import rx_page_ring_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int DEF_START = 64,
  parameter int DEF_STOP  = 128,
  localparam int ADDR_W   = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [PAGE_W-1:0] cfgData,
  input  logic [7:0]        inData,
  output ringStatus_t       status,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [PAGE_W-1:0] curPage,
  output logic [PAGE_W-1:0] bndPage,
  output logic [PAGE_W-1:0] startPage,
  output logic [PAGE_W-1:0] stopPage,
  output logic              overflow
);

  localparam logic [OFF_W-1:0] PAY_OFF = OFF_W'(HDR_BYTES);

  logic [PAGE_W-1:0] startPg, stopPg, curPg, bndPg, wrPg, savedNext, nxtPg, incPg;
  logic [OFF_W-1:0]  wrOff;
  logic [CNT_W-1:0]  byteCnt;
  logic              ovf;
  logic              cfgStart, cfgStop, cfgBound;
  logic [7:0]        hdrByte;

  assign cfgStart = cfgWrEn && (cfgSel == CFG_START) && strobe.cfgOpen;
  assign cfgStop  = cfgWrEn && (cfgSel == CFG_STOP)  && strobe.cfgOpen;
  assign cfgBound = cfgWrEn && (cfgSel == CFG_BOUND);

  // page that follows the page being written, wrapped at the end page
  assign incPg = wrPg + PAGE_W'(1);
  assign nxtPg = (incPg == stopPg) ? startPg : incPg;

  assign status.offEnd = (wrOff == {OFF_W{1'b1}});
  assign status.hitBnd = (nxtPg == bndPg);

  always_comb begin
    case (strobe.hdrIdx)
      2'd0:    hdrByte = HDR_STATUS_OK;
      2'd1:    hdrByte = 8'(savedNext);
      2'd2:    hdrByte = byteCnt[7:0];
      default: hdrByte = byteCnt[15:8];
    endcase
  end

  // ring configuration and boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPg <= PAGE_W'(DEF_START);
      stopPg  <= PAGE_W'(DEF_STOP);
      bndPg   <= PAGE_W'(DEF_START);
      ovf     <= 1'b0;
    end else begin
      if (cfgStart) startPg <= cfgData;
      if (cfgStop)  stopPg  <= cfgData;
      if (cfgStart || cfgBound) bndPg <= cfgData;
      if (cfgBound) ovf <= 1'b0;
      if (strobe.drop) ovf <= 1'b1;
    end
  end

  // write pointer and current page
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPg     <= PAGE_W'(DEF_START);
      wrPg      <= PAGE_W'(DEF_START);
      wrOff     <= PAY_OFF;
      savedNext <= '0;
      byteCnt   <= '0;
    end else begin
      if (strobe.accept) byteCnt <= strobe.firstByte ? CNT_W'(1) : byteCnt + 1'b1;
      if (strobe.endOk)  savedNext <= nxtPg;
      if (cfgStart) begin
        curPg <= cfgData;
        wrPg  <= cfgData;
        wrOff <= PAY_OFF;
      end else if (strobe.commit) begin
        curPg <= savedNext;
        wrPg  <= savedNext;
        wrOff <= PAY_OFF;
      end else if (strobe.drop) begin
        wrPg  <= curPg;
        wrOff <= PAY_OFF;
      end else if (strobe.advance) begin
        if (status.offEnd) begin
          wrPg  <= nxtPg;
          wrOff <= '0;
        end else begin
          wrOff <= wrOff + 1'b1;
        end
      end
    end
  end

  // registered memory write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrEn <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWrEn <= strobe.accept || strobe.hdrWr;
      if (strobe.hdrWr) begin
        memAddr <= {curPg, OFF_W'(strobe.hdrIdx)};
        memData <= hdrByte;
      end else if (strobe.accept) begin
        memAddr <= {wrPg, wrOff};
        memData <= inData;
      end
    end
  end

  assign curPage   = curPg;
  assign bndPage   = bndPg;
  assign startPage = startPg;
  assign stopPage  = stopPg;
  assign overflow  = ovf;

endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring
  import rx_page_ring_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int DEF_START = 64,
  parameter int DEF_STOP  = 128,
  localparam int ADDR_W   = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [PAGE_W-1:0] cfgData,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [PAGE_W-1:0] curPage,
  output logic [PAGE_W-1:0] bndPage,
  output logic              overflow
);

  ringStrobe_t       strobe;
  ringStatus_t       status;
  logic [PAGE_W-1:0] startPage, stopPage;

  rx_ring_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .status  (status),
    .strobe  (strobe),
    .inReady (inReady)
  );

  rx_ring_datapath #(
    .PAGE_W    (PAGE_W),
    .OFF_W     (OFF_W),
    .DEF_START (DEF_START),
    .DEF_STOP  (DEF_STOP)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgData   (cfgData),
    .inData    (inData),
    .status    (status),
    .memWrEn   (memWrEn),
    .memAddr   (memAddr),
    .memData   (memData),
    .curPage   (curPage),
    .bndPage   (bndPage),
    .startPage (startPage),
    .stopPage  (stopPage),
    .overflow  (overflow)
  );

endmodule

// File: rtl/rx_page_ring_chk.sv
module rx_page_ring_chk #(
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [1:0]        cfgSel,
  input logic [PAGE_W-1:0] cfgData,
  input logic              inValid,
  input logic              inLast,
  input logic              inReady,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic [PAGE_W-1:0] curPage,
  input logic [PAGE_W-1:0] bndPage,
  input logic [PAGE_W-1:0] startPage,
  input logic [PAGE_W-1:0] stopPage,
  input logic              overflow
);

  assert_bnd_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel == 2'd3) |=> (bndPage == $past(cfgData)));

  assert_cur_held_on_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $stable(curPage));

  assert_addr_in_ring_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && stopPage > startPage) |->
      (memAddr[ADDR_W-1:OFF_W] >= startPage && memAddr[ADDR_W-1:OFF_W] < stopPage));

  assert_gap_after_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inReady) |-> $past(inValid && inLast));

  assert_hdr_writes_R6: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> memWrEn);

  assert_write_has_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ($past(inValid) || !$past(inReady)));

endmodule

bind rx_page_ring rx_page_ring_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgSel    (cfgSel),
  .cfgData   (cfgData),
  .inValid   (inValid),
  .inLast    (inLast),
  .inReady   (inReady),
  .memWrEn   (memWrEn),
  .memAddr   (memAddr),
  .curPage   (curPage),
  .bndPage   (bndPage),
  .startPage (startPage),
  .stopPage  (stopPage),
  .overflow  (overflow)
);

// File: tb/rx_page_ring_tb_top.sv
module rx_page_ring_tb_top;

  localparam int PAGE_W = 8;
  localparam int OFF_W  = 4;
  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam int PG_BYTES = 1 << OFF_W;
  localparam logic [7:0] RING_LO = 8'h10;
  localparam logic [7:0] RING_HI = 8'h14;

  typedef struct packed {
    logic       doBnd;
    logic [7:0] bnd;
    logic [7:0] len;
    logic [7:0] expCur;
    logic       expDrop;
    logic [7:0] expWr;
  } vecRow_t;

  localparam int NROWS = 8;
  localparam vecRow_t VECS [0:NROWS-1] = '{
    '{1'b0, 8'h00, 8'd5,  8'h11, 1'b0, 8'd9},
    '{1'b0, 8'h00, 8'd12, 8'h12, 1'b0, 8'd16},
    '{1'b0, 8'h00, 8'd13, 8'h12, 1'b1, 8'd13},
    '{1'b1, 8'h12, 8'd13, 8'h10, 1'b0, 8'd17},
    '{1'b0, 8'h00, 8'd1,  8'h11, 1'b0, 8'd5},
    '{1'b0, 8'h00, 8'd40, 8'h11, 1'b1, 8'd12},
    '{1'b1, 8'h11, 8'd44, 8'h10, 1'b0, 8'd48},
    '{1'b0, 8'h00, 8'd1,  8'h10, 1'b1, 8'd1}
  };

  logic clk = 1'b0;
  logic rstN;
  logic cfgWrEn;
  logic [1:0] cfgSel;
  logic [PAGE_W-1:0] cfgData;
  logic inValid, inLast, inReady;
  logic [7:0] inData;
  logic memWrEn;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memData;
  logic [PAGE_W-1:0] curPage, bndPage;
  logic overflow;

  int checks = 0;
  int failures = 0;
  int wrCount = 0;
  logic [7:0] benchMem [0:(1<<ADDR_W)-1];

  always #5 clk = ~clk;

  rx_page_ring #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .inValid(inValid), .inData(inData), .inLast(inLast), .inReady(inReady),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData),
    .curPage(curPage), .bndPage(bndPage), .overflow(overflow)
  );

  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      benchMem[memAddr] = memData;
      wrCount++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 37 + i + 1);
  endfunction

  function automatic logic [7:0] stepPg(input logic [7:0] p, input int k);
    logic [7:0] q = p;
    for (int j = 0; j < k; j++) q = (q + 8'd1 == RING_HI) ? RING_LO : q + 8'd1;
    return q;
  endfunction

  task automatic cfgWrite(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = val;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgSel = 2'd0;
  endtask

  task automatic sendFrame(input int len, input int seed, input bit busyCfg, output int gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = pat(seed, i); inLast = (i == len - 1);
      if (busyCfg && i == 2) begin
        cfgWrEn = 1'b1; cfgSel = 2'd1; cfgData = 8'h30;
      end else begin
        cfgWrEn = 1'b0; cfgSel = 2'd0;
      end
    end
    gap = 0;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgSel = 2'd0;
    while (!inReady && gap < 10) begin
      gap++;
      inValid = 1'b1; inData = 8'hEE; inLast = 1'b1;
      @(negedge clk);
    end
    inValid = 1'b0; inLast = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkFrame(input logic [7:0] fStart, input int len, input int seed,
                            input logic [7:0] expCur, input bit expDrop, input int expWr,
                            input int wr0, input int gap);
    logic [7:0] lastPg;
    int lastOff;
    check(curPage == expCur, expDrop ? "R8 cur held" : "R6 cur advanced", curPage, expCur);
    check(overflow == expDrop, "R8 overflow flag", overflow, expDrop);
    check(wrCount - wr0 == expWr, "R8 write count", wrCount - wr0, expWr);
    check(gap == (expDrop ? 0 : 4), "R7 ready gap", gap, expDrop ? 0 : 4);
    if (!expDrop) begin
      lastPg  = stepPg(fStart, (len + 3) / PG_BYTES);
      lastOff = (len + 3) % PG_BYTES;
      check(benchMem[{fStart, 4'd0}] == 8'h01, "R6 status byte", benchMem[{fStart, 4'd0}], 8'h01);
      check(benchMem[{fStart, 4'd1}] == expCur, "R6 next page", benchMem[{fStart, 4'd1}], expCur);
      check(benchMem[{fStart, 4'd2}] == 8'(len), "R6 count low", benchMem[{fStart, 4'd2}], 8'(len));
      check(benchMem[{fStart, 4'd3}] == 8'h00, "R6 count high", benchMem[{fStart, 4'd3}], 8'h00);
      check(benchMem[{fStart, 4'd4}] == pat(seed, 0), "R4 first payload", benchMem[{fStart, 4'd4}], pat(seed, 0));
      check(benchMem[{lastPg, 4'(lastOff)}] == pat(seed, len - 1), "R5 last payload",
            benchMem[{lastPg, 4'(lastOff)}], pat(seed, len - 1));
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int gap, wr0;
    logic [7:0] modelCur;
    rstN = 1'b0; cfgWrEn = 1'b0; cfgSel = 2'd0; cfgData = '0;
    inValid = 1'b0; inData = '0; inLast = 1'b0;
    repeat (3) @(negedge clk);
    check(memWrEn == 1'b0, "R1 no write in reset", memWrEn, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(curPage == 8'h40, "R1 cur reset", curPage, 8'h40);
    check(bndPage == 8'h40, "R1 bnd reset", bndPage, 8'h40);
    check(overflow == 1'b0, "R1 overflow reset", overflow, 0);
    check(memWrEn == 1'b0, "R1 write enable reset", memWrEn, 0);
    check(inReady == 1'b1, "R1 ready reset", inReady, 1);

    cfgWrite(2'd1, RING_LO);
    check(curPage == RING_LO, "R2 start loads cur", curPage, RING_LO);
    check(bndPage == RING_LO, "R2 start loads bnd", bndPage, RING_LO);
    cfgWrite(2'd2, RING_HI);
    modelCur = RING_LO;

    for (int r = 0; r < NROWS; r++) begin
      if (VECS[r].doBnd) begin
        cfgWrite(2'd3, VECS[r].bnd);
        check(bndPage == VECS[r].bnd, "R3 boundary load", bndPage, VECS[r].bnd);
        check(overflow == 1'b0, "R3 overflow cleared", overflow, 0);
      end
      wr0 = wrCount;
      sendFrame(int'(VECS[r].len), r, 1'b0, gap);
      checkFrame(modelCur, int'(VECS[r].len), r, VECS[r].expCur, VECS[r].expDrop,
                 int'(VECS[r].expWr), wr0, gap);
      if (!VECS[r].expDrop) modelCur = VECS[r].expCur;
    end

    // start-page write while a frame is in progress must be ignored (R2)
    cfgWrite(2'd3, 8'h10);
    modelCur = 8'h10;
    wr0 = wrCount;
    sendFrame(5, 9, 1'b1, gap);
    checkFrame(modelCur, 5, 9, 8'h11, 1'b0, 9, wr0, gap);
    check(bndPage == 8'h10, "R2 busy start write ignored", bndPage, 8'h10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule